// File: doc/BRIEF.md
# Conversion Result Bank with Range Status

This block holds the last results of a converter in eight signed 24-bit slots and reports their state to a host. Each result arrives on a valid/ready stream together with a slot index and two digital range flags. The result lands in the chosen slot and marks that slot as unread. It is also compared, as a two's-complement number, against an upper and a lower limit that the host programs. A result above the upper limit, or one that arrives with its overflow flag, latches a per-slot high flag. A result below the lower limit, or one that arrives with its underflow flag, latches a per-slot low flag.

The host reaches the block through a parallel bus with an address, read and write strobes, write data, and read data that is registered. The status word gives the host two views. The ready bit shows whether any slot is still unread, and it clears only as the host reads the slots. The high flags, the low flags and the calibration flag are sticky, and a read of the status word clears them. An active-low interrupt is the OR of every status bit that the host has enabled in a mask register.

The stream input never applies back-pressure. `res_ready` is low only while reset is asserted. From the first clock after reset it stays high, so each cycle with `res_valid` high is one accepted result.

Top module: `conv_result_bank`

## Requirements
- R1: After reset `res_ready` is high. A cycle with `res_valid` and `res_ready` both high writes `res_data` into slot `res_slot`, and any read of that slot afterwards returns the value.
- R2: Slot i is at address 0x30+i (0x30..0x37). The host can write and read each slot. A host write changes the data but does not mark the slot unread. If the converter and the host write the same slot in the same cycle, the converter's value is stored.
- R3: Each slot has an unread bit. The bit is set by a converter write to that slot and cleared by a host read of that slot. Status bit 0 (ready) is the OR of all eight unread bits. If a set and a clear of the same slot meet in one cycle, the bit stays set.
- R4: A read of the status word at 0x38 does not change the ready bit.
- R5: On a converter write to slot i, status bit 8+i is set if the signed result is greater than the upper limit (0x39), or if `res_ovf` is high.
- R6: On a converter write to slot i, status bit 16+i is set if the signed result is less than the lower limit (0x3A), or if `res_unf` is high.
- R7: The bits set under R5 and R6 stay set until the host reads the status word. That read returns the value before the clear. A set of the same bit in the same cycle wins over the clear.
- R8: Status bit 1 is set when `cal_valid` is high with `cal_ovf` high. It is cleared when `cal_valid` is high with `cal_ovf` low, or by a status read. The new calibration result takes precedence over the read.
- R9: `irq_n` is low exactly when the status word ANDed with the mask register (0x3B, one mask bit per status bit) is nonzero. The change shows in the same cycle as the status change.
- R10: Reset values: all slots are 0, the status word is 0, the upper limit is 0x7FFFFF, the lower limit is 0x800000, the mask is 0xFFFFFF and `irq_n` is high.
- R11: Status bits 2..7 always read 0. Writes to 0x38 are ignored. Reads of any address outside 0x30..0x3B return 0, and writes to such addresses are ignored.
- R12: `h_rdata` shows the register that was addressed during the cycle `h_rd` was high, from the next clock edge on. It holds that value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| res_valid | input | 1 | Result stream valid |
| res_ready | output | 1 | Result stream ready, high outside reset |
| res_data | input | 24 | Signed conversion result |
| res_slot | input | 3 | Destination slot index |
| res_ovf | input | 1 | Converter digital overflow flag |
| res_unf | input | 1 | Converter digital underflow flag |
| cal_valid | input | 1 | Gain calibration result strobe |
| cal_ovf | input | 1 | Calibration result saturated |
| h_addr | input | 8 | Host register address |
| h_wr | input | 1 | Host write strobe |
| h_rd | input | 1 | Host read strobe |
| h_wdata | input | 24 | Host write data |
| h_rdata | output | 24 | Registered host read data |
| irq_n | output | 1 | Active-low interrupt |

## Verification
Each state change, whether from an accepted result, a calibration strobe or a host access, takes effect at the clock edge that samples it. `irq_n` follows at that same edge, with no extra register in its path. Read data is due one edge after the read strobe. The bench changes inputs on falling edges and samples outputs on the following falling edge, so every value it checks comes from exactly one rising edge. For the same-cycle cases it drives the converter write and the host read on one falling edge. It then checks both the returned pre-clear word and the status that remains afterwards.

// File: rtl/crb_pkg.sv
package crb_pkg;
  localparam int ST_W       = 24;
  localparam int ST_RDY     = 0;
  localparam int ST_CAL     = 1;
  localparam int ST_HI_LSB  = 8;
  localparam int ST_LO_LSB  = 16;
  // register offsets from the bank base address
  localparam int OFF_STAT   = 8;
  localparam int OFF_UPPER  = 9;
  localparam int OFF_LOWER  = 10;
  localparam int OFF_MASK   = 11;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_SLOT, SEL_STAT, SEL_UPPER, SEL_LOWER, SEL_MASK
  } reg_sel_e;
endpackage

// File: rtl/crb_slot_array.sv
module crb_slot_array #(
  parameter int DATA_W = 24,
  parameter int SLOTS  = 8,
  localparam int IDX_W = $clog2(SLOTS)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cv_we,
  input  logic [IDX_W-1:0]              cv_idx,
  input  logic [DATA_W-1:0]             cv_data,
  input  logic                          hw_we,
  input  logic [IDX_W-1:0]              hw_idx,
  input  logic [DATA_W-1:0]             hw_data,
  input  logic                          hr_re,
  input  logic [IDX_W-1:0]              hr_idx,
  output logic [SLOTS-1:0][DATA_W-1:0]  slot_q,
  output logic [SLOTS-1:0]              unread_q
);
  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    logic cv_hit, hw_hit, hr_hit;
    assign cv_hit = cv_we && (cv_idx == IDX_W'(g));
    assign hw_hit = hw_we && (hw_idx == IDX_W'(g));
    assign hr_hit = hr_re && (hr_idx == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_q[g] <= '0;
      end else if (cv_hit) begin
        slot_q[g] <= cv_data;          // converter wins over host
      end else if (hw_hit) begin
        slot_q[g] <= hw_data;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        unread_q[g] <= 1'b0;
      end else if (cv_hit) begin
        unread_q[g] <= 1'b1;           // a fresh result is never lost
      end else if (hr_hit) begin
        unread_q[g] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/crb_flag_keeper.sv
module crb_flag_keeper #(
  parameter int DATA_W = 24,
  parameter int SLOTS  = 8,
  localparam int IDX_W = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cv_we,
  input  logic [IDX_W-1:0]  cv_idx,
  input  logic [DATA_W-1:0] cv_data,
  input  logic              cv_ovf,
  input  logic              cv_unf,
  input  logic [DATA_W-1:0] upper,
  input  logic [DATA_W-1:0] lower,
  input  logic              cal_valid,
  input  logic              cal_ovf,
  input  logic              st_clr,
  output logic [SLOTS-1:0]  hi_q,
  output logic [SLOTS-1:0]  lo_q,
  output logic              cal_q
);
  logic above, below;

  always_comb begin
    above = cv_ovf || ($signed(cv_data) > $signed(upper));
    below = cv_unf || ($signed(cv_data) < $signed(lower));
  end

  for (genvar g = 0; g < SLOTS; g++) begin : g_flag
    logic hit;
    assign hit = cv_we && (cv_idx == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        hi_q[g] <= 1'b0;
        lo_q[g] <= 1'b0;
      end else begin
        if (hit && above)  hi_q[g] <= 1'b1;
        else if (st_clr)   hi_q[g] <= 1'b0;
        if (hit && below)  lo_q[g] <= 1'b1;
        else if (st_clr)   lo_q[g] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cal_q <= 1'b0;
    else if (cal_valid) cal_q <= cal_ovf;
    else if (st_clr)    cal_q <= 1'b0;
  end
endmodule

// File: rtl/crb_host_regs.sv
module crb_host_regs
  import crb_pkg::*;
#(
  parameter int              DATA_W = 24,
  parameter int              SLOTS  = 8,
  parameter int              ADDR_W = 8,
  parameter logic [ADDR_W-1:0] BASE = 8'h30,
  localparam int             IDX_W  = $clog2(SLOTS)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [ADDR_W-1:0]            h_addr,
  input  logic                         h_wr,
  input  logic                         h_rd,
  input  logic [DATA_W-1:0]            h_wdata,
  input  logic [SLOTS-1:0][DATA_W-1:0] slot_q,
  input  logic [ST_W-1:0]              status,
  output logic [DATA_W-1:0]            h_rdata,
  output logic [DATA_W-1:0]            upper_q,
  output logic [DATA_W-1:0]            lower_q,
  output logic [ST_W-1:0]              mask_q,
  output logic                         hw_we,
  output logic                         hr_re,
  output logic [IDX_W-1:0]             idx,
  output logic                         st_clr
);
  logic [ADDR_W-1:0] off;
  logic              in_bank;
  reg_sel_e          sel;

  assign off     = h_addr - BASE;
  assign in_bank = (h_addr >= BASE);
  assign idx     = off[IDX_W-1:0];

  always_comb begin
    sel = SEL_NONE;
    if (in_bank) begin
      if (off < ADDR_W'(SLOTS))               sel = SEL_SLOT;
      else if (off == ADDR_W'(OFF_STAT))      sel = SEL_STAT;
      else if (off == ADDR_W'(OFF_UPPER))     sel = SEL_UPPER;
      else if (off == ADDR_W'(OFF_LOWER))     sel = SEL_LOWER;
      else if (off == ADDR_W'(OFF_MASK))      sel = SEL_MASK;
    end
  end

  assign hw_we  = h_wr && (sel == SEL_SLOT);
  assign hr_re  = h_rd && (sel == SEL_SLOT);
  assign st_clr = h_rd && (sel == SEL_STAT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upper_q <= {1'b0, {(DATA_W-1){1'b1}}};
      lower_q <= {1'b1, {(DATA_W-1){1'b0}}};
      mask_q  <= '1;
    end else if (h_wr) begin
      case (sel)
        SEL_UPPER: upper_q <= h_wdata;
        SEL_LOWER: lower_q <= h_wdata;
        SEL_MASK:  mask_q  <= ST_W'(h_wdata);
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_rdata <= '0;
    end else if (h_rd) begin
      case (sel)
        SEL_SLOT:  h_rdata <= slot_q[idx];
        SEL_STAT:  h_rdata <= DATA_W'(status);
        SEL_UPPER: h_rdata <= upper_q;
        SEL_LOWER: h_rdata <= lower_q;
        SEL_MASK:  h_rdata <= DATA_W'(mask_q);
        default:   h_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/conv_result_bank.sv
module conv_result_bank
  import crb_pkg::*;
#(
  parameter int DATA_W = 24,
  parameter int SLOTS  = 8,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] BASE = 8'h30,
  localparam int IDX_W = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              res_valid,
  output logic              res_ready,
  input  logic [DATA_W-1:0] res_data,
  input  logic [IDX_W-1:0]  res_slot,
  input  logic              res_ovf,
  input  logic              res_unf,
  input  logic              cal_valid,
  input  logic              cal_ovf,
  input  logic [ADDR_W-1:0] h_addr,
  input  logic              h_wr,
  input  logic              h_rd,
  input  logic [DATA_W-1:0] h_wdata,
  output logic [DATA_W-1:0] h_rdata,
  output logic              irq_n
);
  logic                         ready_q;
  logic                         accept;
  logic [SLOTS-1:0][DATA_W-1:0] slot_q;
  logic [SLOTS-1:0]             unread_q, hi_q, lo_q;
  logic                         cal_q;
  logic [DATA_W-1:0]            upper_q, lower_q;
  logic [ST_W-1:0]              mask_q, status_word;
  logic                         hw_we, hr_re, st_clr;
  logic [IDX_W-1:0]             h_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ready_q <= 1'b0;
    else        ready_q <= 1'b1;
  end
  assign res_ready = ready_q;
  assign accept    = res_valid && ready_q;

  crb_slot_array #(.DATA_W(DATA_W), .SLOTS(SLOTS)) u_slots (
    .clk(clk), .rst_n(rst_n),
    .cv_we(accept), .cv_idx(res_slot), .cv_data(res_data),
    .hw_we(hw_we), .hw_idx(h_idx), .hw_data(h_wdata),
    .hr_re(hr_re), .hr_idx(h_idx),
    .slot_q(slot_q), .unread_q(unread_q)
  );

  crb_flag_keeper #(.DATA_W(DATA_W), .SLOTS(SLOTS)) u_flags (
    .clk(clk), .rst_n(rst_n),
    .cv_we(accept), .cv_idx(res_slot), .cv_data(res_data),
    .cv_ovf(res_ovf), .cv_unf(res_unf),
    .upper(upper_q), .lower(lower_q),
    .cal_valid(cal_valid), .cal_ovf(cal_ovf), .st_clr(st_clr),
    .hi_q(hi_q), .lo_q(lo_q), .cal_q(cal_q)
  );

  crb_host_regs #(.DATA_W(DATA_W), .SLOTS(SLOTS), .ADDR_W(ADDR_W), .BASE(BASE)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .h_addr(h_addr), .h_wr(h_wr), .h_rd(h_rd), .h_wdata(h_wdata),
    .slot_q(slot_q), .status(status_word), .h_rdata(h_rdata),
    .upper_q(upper_q), .lower_q(lower_q), .mask_q(mask_q),
    .hw_we(hw_we), .hr_re(hr_re), .idx(h_idx), .st_clr(st_clr)
  );

  always_comb begin
    status_word                       = '0;
    status_word[ST_RDY]               = |unread_q;
    status_word[ST_CAL]               = cal_q;
    status_word[ST_HI_LSB +: SLOTS]   = hi_q;
    status_word[ST_LO_LSB +: SLOTS]   = lo_q;
  end

  assign irq_n = ~|(status_word & mask_q);
endmodule

// File: rtl/crb_checker.sv
module crb_checker #(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] BASE = 8'h30
) (
  input logic              clk,
  input logic              rst_n,
  input logic              res_valid,
  input logic              res_ready,
  input logic              cal_valid,
  input logic              cal_ovf,
  input logic              h_rd,
  input logic              h_wr,
  input logic [ADDR_W-1:0] h_addr,
  input logic [23:0]       status,
  input logic [23:0]       mask,
  input logic              irq_n
);
  logic stat_rd;
  assign stat_rd = h_rd && (h_addr == BASE + ADDR_W'(8));

  assert_accept_marks_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_ready) |=> status[0]);

  assert_status_read_keeps_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && status[0]) |=> status[0]);

  assert_sticky_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_rd |=> ((status[23:8] & $past(status[23:8])) == $past(status[23:8])));

  assert_cal_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_valid && cal_ovf) |=> status[1]);

  assert_cal_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_valid && !cal_ovf) |=> !status[1]);

  assert_irq_on_result_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_ready && mask[0] && !h_wr) |=> !irq_n);

  assert_irq_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (status == 24'h0) |-> irq_n);

  assert_reserved_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    status[7:2] == 6'h0);
endmodule

bind conv_result_bank crb_checker #(.ADDR_W(ADDR_W), .BASE(BASE)) u_chk (
  .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_ready(res_ready),
  .cal_valid(cal_valid), .cal_ovf(cal_ovf), .h_rd(h_rd), .h_wr(h_wr),
  .h_addr(h_addr), .status(status_word), .mask(mask_q), .irq_n(irq_n)
);

// File: tb/sim_conv_result_bank.sv
module sim_conv_result_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        res_valid = 1'b0, res_ovf = 1'b0, res_unf = 1'b0;
  logic        res_ready;
  logic [23:0] res_data = '0;
  logic [2:0]  res_slot = '0;
  logic        cal_valid = 1'b0, cal_ovf = 1'b0;
  logic [7:0]  h_addr = '0;
  logic        h_wr = 1'b0, h_rd = 1'b0;
  logic [23:0] h_wdata = '0;
  logic [23:0] h_rdata;
  logic        irq_n;
  int          vectors = 0;
  int          errs = 0;
  logic [23:0] rd;

  localparam logic [7:0] A_STAT = 8'h38, A_UP = 8'h39, A_LO = 8'h3A, A_MASK = 8'h3B;

  always #4 clk = ~clk;

  conv_result_bank u0 (
    .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_ready(res_ready),
    .res_data(res_data), .res_slot(res_slot), .res_ovf(res_ovf), .res_unf(res_unf),
    .cal_valid(cal_valid), .cal_ovf(cal_ovf), .h_addr(h_addr), .h_wr(h_wr),
    .h_rd(h_rd), .h_wdata(h_wdata), .h_rdata(h_rdata), .irq_n(irq_n)
  );

  task automatic chk(input string tag, input logic [23:0] got, input logic [23:0] exp);
    vectors++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [23:0] st(bit rdy, bit cal, logic [7:0] hi, logic [7:0] lo);
    return {lo, hi, 6'b0, cal, rdy};
  endfunction

  // all tasks start and end on a falling edge
  task automatic hwrite(input logic [7:0] a, input logic [23:0] d);
    h_addr = a; h_wdata = d; h_wr = 1'b1;
    @(negedge clk); h_wr = 1'b0;
  endtask

  task automatic hread(input logic [7:0] a, output logic [23:0] d);
    h_addr = a; h_rd = 1'b1;
    @(negedge clk); h_rd = 1'b0; d = h_rdata;
  endtask

  task automatic push(input logic [2:0] s, input logic [23:0] d, input bit ov, input bit un);
    res_slot = s; res_data = d; res_ovf = ov; res_unf = un; res_valid = 1'b1;
    @(negedge clk); res_valid = 1'b0; res_ovf = 1'b0; res_unf = 1'b0;
  endtask

  task automatic cal(input bit ov);
    cal_valid = 1'b1; cal_ovf = ov;
    @(negedge clk); cal_valid = 1'b0; cal_ovf = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errs++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 reset state
    chk("R10 irq_n", {23'b0, irq_n}, 24'h1);
    chk("R1 res_ready", {23'b0, res_ready}, 24'h1);
    for (int s = 0; s < 8; s++) begin
      hread(8'h30 + 8'(s), rd); chk("R10 slot", rd, 24'h0);
    end
    hread(A_STAT, rd); chk("R10 status", rd, 24'h0);
    hread(A_UP, rd);   chk("R10 upper", rd, 24'h7FFFFF);
    hread(A_LO, rd);   chk("R10 lower", rd, 24'h800000);
    hread(A_MASK, rd); chk("R10 mask", rd, 24'hFFFFFF);

    // R2 host slot access, no unread
    hwrite(8'h35, 24'hABCDEF);
    hread(8'h35, rd);  chk("R2 slot rw", rd, 24'hABCDEF);
    hread(A_STAT, rd); chk("R2 no unread", rd, 24'h0);
    chk("R12 hold", h_rdata, 24'h0);

    // R2 converter beats host on same slot
    res_slot = 3'd4; res_data = 24'h111111; res_valid = 1'b1;
    h_addr = 8'h34; h_wdata = 24'h222222; h_wr = 1'b1;
    @(negedge clk); res_valid = 1'b0; h_wr = 1'b0;
    hread(8'h34, rd);  chk("R2 conv wins", rd, 24'h111111);

    // R11 reserved and ignored accesses
    hwrite(A_STAT, 24'hFFFFFF);
    hread(A_STAT, rd); chk("R11 status write ignored", rd, 24'h0);
    hwrite(8'h3C, 24'h123456);
    hread(8'h3C, rd);  chk("R11 unmapped high", rd, 24'h0);
    hread(8'h2F, rd);  chk("R11 unmapped low", rd, 24'h0);

    // thresholds +100 / -100
    hwrite(A_UP, 24'd100);
    hwrite(A_LO, 24'hFFFF9C);
    hread(A_UP, rd); chk("R5 upper rw", rd, 24'd100);
    hread(A_LO, rd); chk("R6 lower rw", rd, 24'hFFFF9C);

    // sweep of slots, values and range flags
    for (int s = 0; s < 8; s++) begin
      for (int k = 0; k < 7; k++) begin
        for (int f = 0; f < 3; f++) begin
          int v;
          bit ov, un, eh, el;
          case (k)
            0: v = -101; 1: v = -100; 2: v = 0; 3: v = 100;
            4: v = 101; 5: v = 8388607; default: v = -8388608;
          endcase
          ov = (f == 1); un = (f == 2);
          eh = (v > 100) || ov;
          el = (v < -100) || un;
          push(3'(s), 24'(v), ov, un);
          chk("R9 irq on result", {23'b0, irq_n}, 24'h0);
          hread(A_STAT, rd);
          chk("R5 R6 R3 status after result", rd,
              st(1, 0, 8'(eh) << s, 8'(el) << s));
          hread(A_STAT, rd);
          chk("R4 R7 status after clear", rd, st(1, 0, 0, 0));
          hread(8'h30 + 8'(s), rd);
          chk("R1 slot data", rd, 24'(v));
          hread(A_STAT, rd);
          chk("R3 ready clears on slot read", rd, 24'h0);
          chk("R9 irq idle", {23'b0, irq_n}, 24'h1);
        end
      end
    end

    // R3 ready is OR over slots
    push(3'd1, 24'd5, 0, 0);
    push(3'd6, 24'd6, 0, 0);
    hread(8'h31, rd);
    hread(A_STAT, rd); chk("R3 one slot still unread", rd, st(1, 0, 0, 0));
    hread(8'h36, rd);
    hread(A_STAT, rd); chk("R3 all read", rd, 24'h0);

    // R3 set beats clear in one cycle
    push(3'd2, 24'd10, 0, 0);
    res_slot = 3'd2; res_data = 24'd20; res_valid = 1'b1;
    h_addr = 8'h32; h_rd = 1'b1;
    @(negedge clk); res_valid = 1'b0; h_rd = 1'b0;
    chk("R12 old slot data", h_rdata, 24'd10);
    hread(A_STAT, rd); chk("R3 set wins", rd, st(1, 0, 0, 0));
    hread(8'h32, rd);  chk("R1 new slot data", rd, 24'd20);
    hread(A_STAT, rd); chk("R3 cleared", rd, 24'h0);

    // R7 sticky set beats status-read clear
    push(3'd3, 24'd200, 0, 0);
    res_slot = 3'd3; res_data = 24'd300; res_valid = 1'b1;
    h_addr = A_STAT; h_rd = 1'b1;
    @(negedge clk); res_valid = 1'b0; h_rd = 1'b0;
    chk("R7 pre-clear value", h_rdata, st(1, 0, 8'h08, 0));
    hread(A_STAT, rd); chk("R7 set wins", rd, st(1, 0, 8'h08, 0));
    hread(8'h33, rd);
    hread(A_STAT, rd); chk("R7 cleared", rd, 24'h0);

    // R8 calibration flag
    cal(1);
    chk("R9 irq on cal", {23'b0, irq_n}, 24'h0);
    hread(A_STAT, rd); chk("R8 cal set", rd, st(0, 1, 0, 0));
    hread(A_STAT, rd); chk("R8 cal read-cleared", rd, 24'h0);
    cal(1);
    cal(0);
    hread(A_STAT, rd); chk("R8 cal cleared by good cal", rd, 24'h0);
    cal(1);
    cal_valid = 1'b1; cal_ovf = 1'b1; h_addr = A_STAT; h_rd = 1'b1;
    @(negedge clk); cal_valid = 1'b0; cal_ovf = 1'b0; h_rd = 1'b0;
    hread(A_STAT, rd); chk("R8 cal beats read", rd, st(0, 1, 0, 0));

    // R9 mask
    hwrite(A_MASK, 24'h000100);
    push(3'd0, 24'd0, 0, 0);
    chk("R9 ready masked", {23'b0, irq_n}, 24'h1);
    push(3'd0, 24'd500, 0, 0);
    chk("R9 high flag enabled", {23'b0, irq_n}, 24'h0);
    hread(A_STAT, rd);
    chk("R9 irq after clear", {23'b0, irq_n}, 24'h1);
    hwrite(A_MASK, 24'h000000);
    push(3'd7, 24'd900, 0, 1);
    chk("R9 all masked", {23'b0, irq_n}, 24'h1);
    hwrite(A_MASK, 24'h010000);
    chk("R9 unmask low slot0", {23'b0, irq_n}, 24'h1);
    hwrite(A_MASK, 24'h800000);
    chk("R9 unmask low slot7", {23'b0, irq_n}, 24'h0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end
endmodule